// File: doc/BRIEF.md
# Serial NAND feature register responder

This block sits on the device side of a four-wire SPI link (mode 0) and behaves like the feature and status registers of a serial NAND flash. A host controller under test sees it as a flash device. It can read three feature registers, selected by an address byte, and write the two that hold settings. It can also read a three-byte identification code and issue a software reset. No array storage, page buffer or quad I/O is modelled.

The SPI pins are sampled with the block's own system clock through two-stage synchronizers, so the serial clock must run well below the system clock. A second, side-band set of inputs lets a testbench start a simulated program or erase operation. The operation has a chosen busy length and chosen fail outcomes. The same inputs can load the two-bit ECC status code at any time. The status register at address 0xC0 reflects all of this. Bit 0 is busy, bit 2 is erase fail, bit 3 is program fail, bits [5:4] are ECC status, and the other bits read 0.

Top module: `snand_feature_resp`

## Requirements
- R1: After rst_n is released, register 0xA0 reads 0x7C, register 0xB0 reads 0x18 and register 0xC0 reads 0x00.
- R2: A get-feature command is opcode 0x0F or 0x05, then an address byte. The selected register value is then returned MSB first, and it is repeated in every further byte while chip select stays low. An address other than 0xA0, 0xB0 or 0xC0 reads 0x00.
- R3: Set-feature is opcode 0x01, then an address byte, then a data byte. At 0xA0 only data bits [6:2] (block protect) are kept. At 0xB0 only bit 4 (ECC enable) and bit 3 (buffer mode) are kept. All other bits read 0. Only the first data byte is written, and later bytes in the same frame are ignored.
- R4: Set-feature to 0xC0 or to any unknown address changes no register.
- R5: After opcode 0x9F the next three bytes return the ID parameter, most significant byte first (default EF AA 21). Any byte after those three is 0x00.
- R6: Opcode 0xFF takes effect at the end of its eighth bit. It restores 0xA0 to 0x7C and 0xB0 to 0x18, clears the fail and ECC status bits, and aborts any running operation. It then shows busy for RST_BUSY cycles.
- R7: A pulse on sb_op_go clears bits [3:2] and sets busy for max(sb_op_len,1) cycles. When busy ends, bit 3 takes the sb_op_pfail value and bit 2 takes the sb_op_efail value, both latched at the start.
- R8: A pulse on sb_ecc_wr loads sb_ecc_val into bits [5:4]. The start or end of an operation leaves them unchanged, and this holds even when the load falls in the same cycle as sb_op_go.
- R9: If sb_op_go arrives in the same cycle that a running operation would finish, the new operation wins. Busy stays set and the fail outcome of the old operation is dropped.
- R10: spi_miso is 0 while chip select is high, during the opcode byte, and for every byte of an unknown opcode.
- R11: Get-feature and set-feature commands are served while busy is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_sck | input | 1 | Serial clock, mode 0 |
| spi_cs_n | input | 1 | Chip select, active low |
| spi_mosi | input | 1 | Serial data from host |
| spi_miso | output | 1 | Serial data to host |
| sb_op_go | input | 1 | Start a simulated program/erase operation |
| sb_op_len | input | LEN_W | Busy length of that operation in cycles |
| sb_op_pfail | input | 1 | Operation ends with program fail |
| sb_op_efail | input | 1 | Operation ends with erase fail |
| sb_ecc_wr | input | 1 | Load ECC status code |
| sb_ecc_val | input | 2 | ECC status code to load |

## Verification
Two pairs of events can fall in the same cycle. The first pair is the end of a running operation and a new sb_op_go. The bench counts clock edges from the first start and raises the second start in exactly the cycle where the first would finish. It then reads 0xC0 over SPI: busy must still be set with no program fail shown, and the erase fail of the second operation must appear once it ends. The second pair is an ECC load and an operation start in the same cycle. The bench checks that the ECC code appears while the fail bits are cleared, and that the code survives the end of the operation.

// File: rtl/snand_pkg.sv
package snand_pkg;
  localparam logic [7:0] OP_GET_A = 8'h0F;
  localparam logic [7:0] OP_GET_B = 8'h05;
  localparam logic [7:0] OP_SET   = 8'h01;
  localparam logic [7:0] OP_ID    = 8'h9F;
  localparam logic [7:0] OP_RST   = 8'hFF;

  localparam logic [7:0] FA_PROT  = 8'hA0;
  localparam logic [7:0] FA_CONF  = 8'hB0;
  localparam logic [7:0] FA_STAT  = 8'hC0;

  localparam int PROT_W = 5;

  typedef struct packed {
    logic [1:0] ecc;
    logic       pfail;
    logic       efail;
    logic       busy;
  } stat_t;

  typedef struct packed {
    logic ecc_en;
    logic buf_mode;
  } conf_t;

  function automatic logic [7:0] pack_status(stat_t s);
    return {2'b00, s.ecc, s.pfail, s.efail, 1'b0, s.busy};
  endfunction

  function automatic logic is_get(logic [7:0] cmd);
    return (cmd == OP_GET_A) || (cmd == OP_GET_B);
  endfunction

  function automatic logic [7:0] feat_value(logic [7:0] addr, logic [PROT_W-1:0] prot,
                                            conf_t conf, stat_t st);
    case (addr)
      FA_PROT: return {1'b0, prot, 2'b00};
      FA_CONF: return {3'b000, conf.ecc_en, conf.buf_mode, 3'b000};
      FA_STAT: return pack_status(st);
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic [7:0] reply_byte(logic [7:0] cmd, logic [2:0] k,
                                            logic [7:0] feat, logic [23:0] id);
    if (cmd == OP_ID) begin
      case (k)
        3'd1:    return id[23:16];
        3'd2:    return id[15:8];
        3'd3:    return id[7:0];
        default: return 8'h00;
      endcase
    end
    if (is_get(cmd) && (k >= 3'd2)) return feat;
    return 8'h00;
  endfunction
endpackage

// File: rtl/snand_spi_port.sv
module snand_spi_port #(
  parameter int IDX_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sck,
  input  logic             cs_n,
  input  logic             mosi,
  input  logic [7:0]       reply,
  output logic             miso,
  output logic             active,
  output logic             rx_vld,
  output logic [7:0]       rx_byte,
  output logic [IDX_W-1:0] rx_num,
  output logic [IDX_W-1:0] cur_idx
);
  localparam logic [IDX_W-1:0] IDX_MAX = {IDX_W{1'b1}};

  logic [2:0]       sck_p;
  logic [1:0]       cs_p;
  logic [1:0]       mosi_p;
  logic             rise, fall, mosi_s;
  logic [2:0]       bit_cnt;
  logic [6:0]       rx_sr;
  logic [7:0]       tx_sr;
  logic             fresh;
  logic [IDX_W-1:0] byte_idx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_p  <= '0;
      cs_p   <= '1;
      mosi_p <= '0;
    end else begin
      sck_p  <= {sck_p[1:0], sck};
      cs_p   <= {cs_p[0], cs_n};
      mosi_p <= {mosi_p[0], mosi};
    end
  end

  assign active  = ~cs_p[1];
  assign mosi_s  = mosi_p[1];
  assign rise    = sck_p[1] & ~sck_p[2];
  assign fall    = ~sck_p[1] & sck_p[2];
  assign cur_idx = byte_idx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_cnt  <= '0;
      rx_sr    <= '0;
      tx_sr    <= '0;
      fresh    <= 1'b0;
      byte_idx <= '0;
      miso     <= 1'b0;
      rx_vld   <= 1'b0;
      rx_byte  <= '0;
      rx_num   <= '0;
    end else begin
      rx_vld <= 1'b0;
      if (!active) begin
        bit_cnt  <= '0;
        tx_sr    <= '0;
        fresh    <= 1'b0;
        byte_idx <= '0;
        miso     <= 1'b0;
      end else if (rise) begin
        rx_sr   <= {rx_sr[5:0], mosi_s};
        bit_cnt <= bit_cnt + 3'd1;
        if (bit_cnt == 3'd7) begin
          rx_vld  <= 1'b1;
          rx_byte <= {rx_sr, mosi_s};
          rx_num  <= byte_idx;
          fresh   <= 1'b1;
          if (byte_idx != IDX_MAX) byte_idx <= byte_idx + 1'b1;
        end
      end else if (fall) begin
        if (fresh) begin
          miso  <= reply[7];
          tx_sr <= {reply[6:0], 1'b0};
          fresh <= 1'b0;
        end else begin
          miso  <= tx_sr[7];
          tx_sr <= {tx_sr[6:0], 1'b0};
        end
      end
    end
  end
endmodule

// File: rtl/snand_feat_regs.sv
module snand_feat_regs
  import snand_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rst_evt,
  input  logic              wr_evt,
  input  logic [7:0]        wr_addr,
  input  logic [7:0]        wr_data,
  output logic [PROT_W-1:0] prot,
  output conf_t             conf
);
  localparam logic [PROT_W-1:0] PROT_RST = '1;
  localparam conf_t             CONF_RST = '{ecc_en: 1'b1, buf_mode: 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prot <= PROT_RST;
      conf <= CONF_RST;
    end else if (rst_evt) begin
      prot <= PROT_RST;
      conf <= CONF_RST;
    end else if (wr_evt) begin
      if (wr_addr == FA_PROT) prot <= wr_data[6:2];
      if (wr_addr == FA_CONF) conf <= '{ecc_en: wr_data[4], buf_mode: wr_data[3]};
    end
  end
endmodule

// File: rtl/snand_status.sv
module snand_status
  import snand_pkg::*;
#(
  parameter int LEN_W    = 16,
  parameter int RST_BUSY = 100
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rst_evt,
  input  logic             go,
  input  logic [LEN_W-1:0] len,
  input  logic             pf_in,
  input  logic             ef_in,
  input  logic             ecc_wr,
  input  logic [1:0]       ecc_in,
  output stat_t            st,
  output logic             done
);
  localparam int RST_LEN = (RST_BUSY < 1) ? 1 : RST_BUSY;

  logic [LEN_W-1:0] cnt;
  logic             pend_p, pend_e;

  function automatic logic [LEN_W-1:0] load_len(logic [LEN_W-1:0] l);
    return (l == '0) ? LEN_W'(1) : l;
  endfunction

  assign done = st.busy && (cnt == LEN_W'(1)) && !go && !rst_evt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st.busy  <= 1'b0;
      st.pfail <= 1'b0;
      st.efail <= 1'b0;
      cnt      <= '0;
      pend_p   <= 1'b0;
      pend_e   <= 1'b0;
    end else if (rst_evt) begin
      st.busy  <= 1'b1;
      st.pfail <= 1'b0;
      st.efail <= 1'b0;
      cnt      <= LEN_W'(RST_LEN);
      pend_p   <= 1'b0;
      pend_e   <= 1'b0;
    end else if (go) begin
      st.busy  <= 1'b1;
      st.pfail <= 1'b0;
      st.efail <= 1'b0;
      cnt      <= load_len(len);
      pend_p   <= pf_in;
      pend_e   <= ef_in;
    end else if (done) begin
      st.busy  <= 1'b0;
      st.pfail <= pend_p;
      st.efail <= pend_e;
      cnt      <= '0;
    end else if (st.busy) begin
      cnt <= cnt - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       st.ecc <= 2'b00;
    else if (rst_evt) st.ecc <= 2'b00;
    else if (ecc_wr)  st.ecc <= ecc_in;
  end
endmodule

// File: rtl/snand_feature_resp.sv
module snand_feature_resp
  import snand_pkg::*;
#(
  parameter int          LEN_W    = 16,
  parameter int          RST_BUSY = 100,
  parameter int          IDX_W    = 3,
  parameter logic [23:0] DEV_ID   = 24'hEFAA21
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             spi_sck,
  input  logic             spi_cs_n,
  input  logic             spi_mosi,
  output logic             spi_miso,
  input  logic             sb_op_go,
  input  logic [LEN_W-1:0] sb_op_len,
  input  logic             sb_op_pfail,
  input  logic             sb_op_efail,
  input  logic             sb_ecc_wr,
  input  logic [1:0]       sb_ecc_val
);
  logic             port_active, rx_vld;
  logic [7:0]       rx_byte, reply, feat;
  logic [IDX_W-1:0] rx_num, cur_idx;
  logic [7:0]       cmd_q, addr_q;
  logic             rst_evt, wr_evt, op_done;
  logic [PROT_W-1:0] prot;
  conf_t            conf;
  stat_t            st;

  assign rst_evt = rx_vld && (rx_num == '0) && (rx_byte == OP_RST);
  assign wr_evt  = rx_vld && (rx_num == IDX_W'(2)) && (cmd_q == OP_SET);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q  <= '0;
      addr_q <= '0;
    end else if (rx_vld) begin
      if (rx_num == '0)        cmd_q  <= rx_byte;
      if (rx_num == IDX_W'(1)) addr_q <= rx_byte;
    end
  end

  assign feat  = feat_value(addr_q, prot, conf, st);
  assign reply = reply_byte(cmd_q, (cur_idx > IDX_W'(7)) ? 3'd7 : 3'(cur_idx), feat, DEV_ID);

  snand_spi_port #(.IDX_W(IDX_W)) u_port (
    .clk(clk), .rst_n(rst_n), .sck(spi_sck), .cs_n(spi_cs_n), .mosi(spi_mosi),
    .reply(reply), .miso(spi_miso), .active(port_active), .rx_vld(rx_vld),
    .rx_byte(rx_byte), .rx_num(rx_num), .cur_idx(cur_idx)
  );

  snand_feat_regs u_regs (
    .clk(clk), .rst_n(rst_n), .rst_evt(rst_evt), .wr_evt(wr_evt),
    .wr_addr(addr_q), .wr_data(rx_byte), .prot(prot), .conf(conf)
  );

  snand_status #(.LEN_W(LEN_W), .RST_BUSY(RST_BUSY)) u_stat (
    .clk(clk), .rst_n(rst_n), .rst_evt(rst_evt), .go(sb_op_go), .len(sb_op_len),
    .pf_in(sb_op_pfail), .ef_in(sb_op_efail), .ecc_wr(sb_ecc_wr), .ecc_in(sb_ecc_val),
    .st(st), .done(op_done)
  );
endmodule

// File: rtl/snand_resp_chk.sv
module snand_resp_chk
  import snand_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              rst_evt,
  input logic              wr_evt,
  input logic [7:0]        wr_addr,
  input logic              go,
  input logic              ecc_wr,
  input logic              op_done,
  input logic              active,
  input logic              miso,
  input logic [PROT_W-1:0] prot,
  input conf_t             conf,
  input stat_t             st
);
  // R6
  reset_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_evt |=> st.busy && (prot == '1) && conf.ecc_en && conf.buf_mode &&
                (st.ecc == 2'b00) && !st.pfail && !st.efail);

  // R7
  op_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    go && !rst_evt |=> st.busy && !st.pfail && !st.efail);

  // R7
  fail_at_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(st.pfail) || $rose(st.efail)) |-> $fell(st.busy));

  // R9
  done_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
    op_done |=> !st.busy);

  // R4
  ro_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_evt && (wr_addr != FA_PROT) && (wr_addr != FA_CONF) |=> $stable(prot) && $stable(conf));

  // R8
  ecc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ecc_wr && !rst_evt |=> $stable(st.ecc));

  // R10
  idle_miso_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> !miso);
endmodule

bind snand_feature_resp snand_resp_chk u_chk (
  .clk(clk), .rst_n(rst_n), .rst_evt(rst_evt), .wr_evt(wr_evt), .wr_addr(addr_q),
  .go(sb_op_go), .ecc_wr(sb_ecc_wr), .op_done(op_done), .active(port_active),
  .miso(spi_miso), .prot(prot), .conf(conf), .st(st)
);

// File: tb/tb_snand_feature_resp.sv
`timescale 1ns/1ps
module tb_snand_feature_resp;
  localparam int LEN_W = 16;
  localparam int RSTB  = 2000;
  localparam int H     = 8;
  localparam int NV    = 18;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sck = 1'b0, cs_n = 1'b1, mosi = 1'b0;
  logic miso;
  logic go = 1'b0, pf = 1'b0, ef = 1'b0, ecc_wr = 1'b0;
  logic [LEN_W-1:0] len = '0;
  logic [1:0] ecc_v = '0;

  int n_chk = 0, n_bad = 0;
  logic finished = 1'b0;
  logic [7:0] txb [8];
  logic [7:0] rxb [8];
  logic [7:0] v;

  always #2.5 clk = ~clk;

  snand_feature_resp #(.LEN_W(LEN_W), .RST_BUSY(RSTB)) dut (
    .clk(clk), .rst_n(rst_n), .spi_sck(sck), .spi_cs_n(cs_n), .spi_mosi(mosi),
    .spi_miso(miso), .sb_op_go(go), .sb_op_len(len), .sb_op_pfail(pf),
    .sb_op_efail(ef), .sb_ecc_wr(ecc_wr), .sb_ecc_val(ecc_v)
  );

  // {opcode, address, data-or-expected}
  localparam logic [23:0] VEC [NV] = '{
    24'h0FA07C, 24'h0FB018, 24'h0FC000, 24'h01A0FF, 24'h0FA07C, 24'h01A000,
    24'h05A000, 24'h01B0E7, 24'h0FB000, 24'h01B008, 24'h05B008, 24'h01C0FF,
    24'h0FC000, 24'h0155FF, 24'h0FA000, 24'h0F5500, 24'h01B010, 24'h0FB010
  };

  function automatic string vec_tag(int i);
    if (i <= 2) return "R1";
    if (i == 12 || i == 14) return "R4";
    if (i == 15) return "R2";
    return "R3";
  endfunction

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %02h expected %02h", tag, got, exp);
    end
  endtask

  task automatic clks(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic xfer(input int n);
    cs_n = 1'b0;
    clks(H);
    for (int b = 0; b < n; b++) begin
      for (int i = 7; i >= 0; i--) begin
        mosi = txb[b][i];
        clks(H);
        rxb[b][i] = miso;
        sck = 1'b1;
        clks(H);
        sck = 1'b0;
      end
    end
    clks(H);
    cs_n = 1'b1;
    clks(2 * H);
  endtask

  task automatic rd(input logic [7:0] op, input logic [7:0] a, output logic [7:0] val);
    txb[0] = op; txb[1] = a; txb[2] = 8'h00;
    xfer(3);
    val = rxb[2];
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    txb[0] = 8'h01; txb[1] = a; txb[2] = d;
    xfer(3);
  endtask

  task automatic op_pulse(input int l, input logic p, input logic e, input logic ew,
                          input logic [1:0] ev);
    @(negedge clk);
    go = 1'b1; len = LEN_W'(l); pf = p; ef = e; ecc_wr = ew; ecc_v = ev;
    @(negedge clk);
    go = 1'b0; pf = 1'b0; ef = 1'b0; ecc_wr = 1'b0;
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    for (int c = 0; c < 200000; c++) begin
      @(posedge clk);
      if (finished) break;
    end
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      summary();
    end
  end

  initial begin
    clks(5);
    rst_n = 1'b1;
    clks(5);
    chk("R10 idle", {7'd0, miso}, 8'h00);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][23:16] == 8'h01) wr(VEC[i][15:8], VEC[i][7:0]);
      else begin
        rd(VEC[i][23:16], VEC[i][15:8], v);
        chk(vec_tag(i), v, VEC[i][7:0]);
      end
    end

    // R5 / R10: identification read
    txb[0] = 8'h9F; for (int b = 1; b < 5; b++) txb[b] = 8'h00;
    xfer(5);
    chk("R10 opcode byte", rxb[0], 8'h00);
    chk("R5 id0", rxb[1], 8'hEF);
    chk("R5 id1", rxb[2], 8'hAA);
    chk("R5 id2", rxb[3], 8'h21);
    chk("R5 after id", rxb[4], 8'h00);

    // R10: unknown opcode answers nothing
    txb[0] = 8'h3C; txb[1] = 8'hB0; txb[2] = 8'h00;
    xfer(3);
    chk("R10 unknown op b1", rxb[1], 8'h00);
    chk("R10 unknown op b2", rxb[2], 8'h00);

    // R2: repeated read byte
    txb[0] = 8'h0F; txb[1] = 8'hB0; txb[2] = 8'h00; txb[3] = 8'h00;
    xfer(4);
    chk("R2 first", rxb[2], 8'h10);
    chk("R2 repeat", rxb[3], 8'h10);

    // R3: only first data byte written
    txb[0] = 8'h01; txb[1] = 8'hA0; txb[2] = 8'h14; txb[3] = 8'h7C;
    xfer(4);
    rd(8'h0F, 8'hA0, v); chk("R3 first data only", v, 8'h14);
    chk("R10 idle again", {7'd0, miso}, 8'h00);

    // R7: program fail
    op_pulse(3000, 1'b1, 1'b0, 1'b0, 2'b00);
    rd(8'h0F, 8'hC0, v); chk("R7 busy", v, 8'h01);
    clks(3000);
    rd(8'h0F, 8'hC0, v); chk("R7 pfail at end", v, 8'h08);
    // R7: erase fail, old flag cleared at start
    op_pulse(3000, 1'b0, 1'b1, 1'b0, 2'b00);
    rd(8'h0F, 8'hC0, v); chk("R7 cleared at start", v, 8'h01);
    clks(3000);
    rd(8'h0F, 8'hC0, v); chk("R7 efail at end", v, 8'h04);

    // R8: ECC code
    @(negedge clk); ecc_wr = 1'b1; ecc_v = 2'd2;
    @(negedge clk); ecc_wr = 1'b0;
    rd(8'h0F, 8'hC0, v); chk("R8 ecc load", v, 8'h24);
    op_pulse(2000, 1'b0, 1'b0, 1'b1, 2'd3);
    rd(8'h0F, 8'hC0, v); chk("R8 ecc with start", v, 8'h31);
    clks(2000);
    rd(8'h0F, 8'hC0, v); chk("R8 ecc after end", v, 8'h30);

    // R7: zero length behaves as one cycle
    op_pulse(0, 1'b1, 1'b0, 1'b0, 2'b00);
    clks(20);
    rd(8'h0F, 8'hC0, v); chk("R7 zero length", v, 8'h38);

    // R9: new start in the finishing cycle of the old one
    op_pulse(500, 1'b1, 1'b0, 1'b0, 2'b00);
    clks(500 - 2);
    op_pulse(3000, 1'b0, 1'b1, 1'b0, 2'b00);
    rd(8'h0F, 8'hC0, v); chk("R9 new op wins", v, 8'h31);
    // R11: register access while busy
    wr(8'hB0, 8'h08);
    rd(8'h0F, 8'hB0, v); chk("R11 write while busy", v, 8'h08);
    rd(8'h0F, 8'hC0, v); chk("R11 still busy", v, 8'h31);
    clks(3000);
    rd(8'h0F, 8'hC0, v); chk("R9 second outcome", v, 8'h34);

    // R6: reset command aborts an operation
    op_pulse(6000, 1'b1, 1'b0, 1'b0, 2'b00);
    txb[0] = 8'hFF;
    xfer(1);
    rd(8'h0F, 8'hC0, v); chk("R6 busy after reset", v, 8'h01);
    clks(6500);
    rd(8'h0F, 8'hC0, v); chk("R6 status cleared", v, 8'h00);
    rd(8'h0F, 8'hA0, v); chk("R6 protect restored", v, 8'h7C);
    rd(8'h0F, 8'hB0, v); chk("R6 config restored", v, 8'h18);

    finished = 1'b1;
    summary();
  end
endmodule